// File: doc/BRIEF.md
# Indirect Configuration and Port Access Bridge

This block turns host register accesses into single downstream bus cycles of two kinds: configuration cycles and I/O-port cycles. Software first loads a 32-bit pointer register with the target address, then touches one of two 4-byte data windows. One window starts a configuration cycle and the other starts an I/O-port cycle. Each access uses byte, halfword or word size, and the low two bits of the window offset pick the byte lanes.

For configuration targets the pointer packs the bus number in bits 23:16, the device/function in bits 15:8 and the register offset in bits 7:0. For I/O targets the pointer holds a plain 16-bit port address. A configuration write is always preceded by a harmless dummy configuration read of register 0 of the same bus and device. This stops the downstream bus from being driven one cycle early when the cycle type changes. The host side stalls until the downstream cycle finishes, so only one cycle is ever outstanding. A cycle that nobody answers is abandoned after a bounded wait.

Top module: `cfgport_bridge`

## Requirements
- R1: The pointer register sits at host offset 0x064 and is accessed as a full 32-bit word whatever the size. A write stores h_wdata. A read returns the stored value. Both complete with h_done one cycle after acceptance, and the register resets to 0.
- R2: An access to the configuration window (0x068..0x06B) issues a downstream cycle with d_kind=0. Its d_addr is the pointer with bits 1:0 cleared, and d_req, d_addr, d_be and d_write stay stable until d_ack.
- R3: Byte enables are active high. For size 0 (byte) d_be = 1 << offset[1:0]. For size 1 (halfword) d_be = 4'b0011 when offset bit 1 is 0 and 4'b1100 when it is 1. For sizes 2 and 3 (word) d_be = 4'b1111.
- R4: On writes, h_wdata is shifted onto the enabled lanes. A byte moves left by 8*offset[1:0] bits, a halfword by 16*offset[1] bits, and a word is passed unchanged.
- R5: On reads, h_rdata returns the enabled lanes of d_rdata shifted down to bit 0 and zero-extended. A window write returns h_rdata = 0.
- R6: A configuration-window write first issues a read cycle (d_write=0) at {pointer[31:8], 8'h00} with d_be=4'b1111. d_req then drops for one cycle, and only after that is the write cycle issued.
- R7: An access to the I/O window (0x06C..0x06F) issues one cycle with d_kind=1 and d_addr = {16'h0, pointer[15:0]}, using the same lane rules as R3 to R5.
- R8: h_ready is low from the edge that accepts a window access until the edge that raises h_done. A request presented while h_ready is low is ignored.
- R9: If d_ack has not arrived after 16 cycles of d_req high, the cycle is dropped. A read then returns 32'hFFFF_FFFF. A write still completes, and a timed-out dummy read still proceeds to the write.
- R10: An access to any other offset causes no downstream cycle. It completes one cycle after acceptance with h_rdata = 0.
- R11: After reset, h_ready=1, h_done=0 and d_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host request, accepted on an edge where h_ready is high |
| h_write | input | 1 | 1 = write, 0 = read |
| h_addr | input | 12 | Host byte offset |
| h_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| h_wdata | input | 32 | Host write data, right-justified |
| h_ready | output | 1 | High when a new request can be accepted |
| h_done | output | 1 | One-cycle completion pulse |
| h_rdata | output | 32 | Read result, valid with h_done |
| d_req | output | 1 | Downstream cycle request, held until d_ack or timeout |
| d_kind | output | 1 | 0 configuration, 1 I/O port |
| d_write | output | 1 | Downstream write |
| d_addr | output | 32 | Downstream address |
| d_be | output | 4 | Active-high byte enables |
| d_wdata | output | 32 | Lane-steered write data |
| d_ack | input | 1 | Completion pulse from the downstream completer |
| d_rdata | input | 32 | Read data, valid with d_ack |

## Verification
The assertions check four things on every cycle. A pending downstream cycle keeps its address and enables stable. The enables always form a legal byte, halfword or word pattern. A configuration write never starts without a finished dummy read ahead of it, and no cycle stays pending past the timeout bound. They also check that a new downstream cycle only starts while the host is stalled, and that non-window accesses finish at once. Only the bench scenarios can show that the data values are right. That covers lane steering and extraction for every size and offset, the packed addresses, the all-ones result after an unanswered read, and that a request made during a stall leaves the pointer register unchanged.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int DW  = 32;
  localparam int BEW = DW / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic KIND_CFG = 1'b0;
  localparam logic KIND_IO  = 1'b1;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_DUMMY = 2'd1,
    S_GAP   = 2'd2,
    S_MAIN  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cpb_lane_pack.sv
module cpb_lane_pack
  import cfgport_pkg::*;
(
  input  logic [1:0]     size,
  input  logic [1:0]     off,
  input  logic [DW-1:0]  wdata,
  output logic [BEW-1:0] be,
  output logic [DW-1:0]  wdata_lane
);
  logic [1:0] eff_off;
  logic [4:0] shamt;

  always_comb begin
    if (size == SZ_BYTE)      eff_off = off;
    else if (size == SZ_HALF) eff_off = {off[1], 1'b0};
    else                      eff_off = 2'b00;
  end

  assign shamt      = {eff_off, 3'b000};
  assign wdata_lane = wdata << shamt;

  for (genvar g = 0; g < BEW; g++) begin : g_lane
    localparam logic [1:0] LN = 2'(g);
    always_comb begin
      if (size == SZ_BYTE)      be[g] = (off == LN);
      else if (size == SZ_HALF) be[g] = (off[1] == LN[1]);
      else                      be[g] = 1'b1;
    end
  end
endmodule

// File: rtl/cpb_lane_unpack.sv
module cpb_lane_unpack
  import cfgport_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [1:0]    off,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] just
);
  logic [DW-1:0] shifted;
  logic [4:0]    shamt;

  always_comb begin
    if (size == SZ_BYTE)      shamt = {off, 3'b000};
    else if (size == SZ_HALF) shamt = {off[1], 4'b0000};
    else                      shamt = 5'd0;
  end

  assign shifted = raw >> shamt;

  always_comb begin
    if (size == SZ_BYTE)      just = {{(DW-8){1'b0}},  shifted[7:0]};
    else if (size == SZ_HALF) just = {{(DW-16){1'b0}}, shifted[15:0]};
    else                      just = shifted;
  end
endmodule

// File: rtl/cpb_cycle_seq.sv
module cpb_cycle_seq
  import cfgport_pkg::*;
#(
  parameter int TMO_CYCLES = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           kind,
  input  logic           write,
  input  logic [DW-1:0]  addr,
  input  logic [BEW-1:0] be,
  input  logic [DW-1:0]  wdata,
  output logic           d_req,
  output logic           d_kind,
  output logic           d_write,
  output logic [DW-1:0]  d_addr,
  output logic [BEW-1:0] d_be,
  output logic [DW-1:0]  d_wdata,
  input  logic           d_ack,
  input  logic [DW-1:0]  d_rdata,
  output logic           done,
  output logic           timed_out,
  output logic [DW-1:0]  rdata
);
  localparam int TW = $clog2(TMO_CYCLES + 1);

  seq_state_e     st;
  logic [TW-1:0]  tmr;
  logic           expire;
  logic           m_write;
  logic [DW-1:0]  m_addr;
  logic [BEW-1:0] m_be;
  logic [DW-1:0]  m_wdata;

  assign expire = (tmr == TW'(TMO_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      tmr       <= '0;
      d_req     <= 1'b0;
      d_kind    <= KIND_CFG;
      d_write   <= 1'b0;
      d_addr    <= '0;
      d_be      <= '0;
      d_wdata   <= '0;
      m_write   <= 1'b0;
      m_addr    <= '0;
      m_be      <= '0;
      m_wdata   <= '0;
      done      <= 1'b0;
      timed_out <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            m_write <= write;
            m_addr  <= addr;
            m_be    <= be;
            m_wdata <= wdata;
            tmr     <= '0;
            d_req   <= 1'b1;
            d_kind  <= kind;
            if (kind == KIND_CFG && write) begin
              d_write <= 1'b0;
              d_addr  <= {addr[DW-1:8], 8'h00};
              d_be    <= '1;
              d_wdata <= '0;
              st      <= S_DUMMY;
            end else begin
              d_write <= write;
              d_addr  <= addr;
              d_be    <= be;
              d_wdata <= wdata;
              st      <= S_MAIN;
            end
          end
        end
        S_DUMMY: begin
          if (d_ack || expire) begin
            d_req <= 1'b0;
            st    <= S_GAP;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_GAP: begin
          d_req   <= 1'b1;
          d_write <= m_write;
          d_addr  <= m_addr;
          d_be    <= m_be;
          d_wdata <= m_wdata;
          tmr     <= '0;
          st      <= S_MAIN;
        end
        S_MAIN: begin
          if (d_ack) begin
            d_req     <= 1'b0;
            done      <= 1'b1;
            timed_out <= 1'b0;
            rdata     <= d_rdata;
            st        <= S_IDLE;
          end else if (expire) begin
            d_req     <= 1'b0;
            done      <= 1'b1;
            timed_out <= 1'b1;
            st        <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // checker state: set once a dummy read has finished in this sequence
  logic dummy_seen;
  always_ff @(posedge clk) begin
    if (rst || st == S_IDLE) dummy_seen <= 1'b0;
    else if (st == S_DUMMY && (d_ack || expire)) dummy_seen <= 1'b1;
  end

  a_r2_req_stable: assert property (@(posedge clk) disable iff (rst)
    (d_req && !d_ack && !expire) |=>
      (d_req && $stable(d_addr) && $stable(d_be) && $stable(d_write)));

  a_r6_dummy_shape: assert property (@(posedge clk) disable iff (rst)
    (st == S_DUMMY) |-> (d_req && !d_write && d_addr[7:0] == 8'h00 && d_be == '1));

  a_r6_dummy_before_write: assert property (@(posedge clk) disable iff (rst)
    ($rose(d_req) && d_write && d_kind == KIND_CFG) |-> dummy_seen);

  a_r9_req_bounded: assert property (@(posedge clk) disable iff (rst)
    d_req |-> (tmr < TW'(TMO_CYCLES)));
endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
  import cfgport_pkg::*;
#(
  parameter int                ADDR_W     = 12,
  parameter int                TMO_CYCLES = 16,
  parameter logic [ADDR_W-1:0] PTR_OFS    = 12'h064,
  parameter logic [ADDR_W-1:0] CFGWIN_OFS = 12'h068,
  parameter logic [ADDR_W-1:0] IOWIN_OFS  = 12'h06C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_req,
  input  logic              h_write,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [1:0]        h_size,
  input  logic [31:0]       h_wdata,
  output logic              h_ready,
  output logic              h_done,
  output logic [31:0]       h_rdata,
  output logic              d_req,
  output logic              d_kind,
  output logic              d_write,
  output logic [31:0]       d_addr,
  output logic [3:0]        d_be,
  output logic [31:0]       d_wdata,
  input  logic              d_ack,
  input  logic [31:0]       d_rdata
);
  localparam int WH = ADDR_W - 2;

  logic [DW-1:0]  ptr_q;
  logic           busy_q;
  logic [1:0]     cap_size;
  logic [1:0]     cap_off;
  logic           cap_write;

  logic           hit_ptr, hit_cfg, hit_io, win_hit, accept;
  logic [BEW-1:0] req_be;
  logic [DW-1:0]  req_wdata;
  logic [DW-1:0]  req_addr;
  logic           seq_done, seq_to;
  logic [DW-1:0]  seq_rdata, rsp_just;

  assign hit_ptr = (h_addr[ADDR_W-1:2] == PTR_OFS[ADDR_W-1:2]);
  assign hit_cfg = (h_addr[ADDR_W-1:2] == CFGWIN_OFS[ADDR_W-1:2]);
  assign hit_io  = (h_addr[ADDR_W-1:2] == IOWIN_OFS[ADDR_W-1:2]);
  assign win_hit = hit_cfg || hit_io;
  assign accept  = h_req && !busy_q;
  assign h_ready = !busy_q;

  assign req_addr = hit_cfg ? {ptr_q[DW-1:2], 2'b00} : {16'h0000, ptr_q[15:0]};

  cpb_lane_pack u_pack (
    .size       (h_size),
    .off        (h_addr[1:0]),
    .wdata      (h_wdata),
    .be         (req_be),
    .wdata_lane (req_wdata)
  );

  cpb_cycle_seq #(.TMO_CYCLES(TMO_CYCLES)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept && win_hit),
    .kind      (hit_io ? KIND_IO : KIND_CFG),
    .write     (h_write),
    .addr      (req_addr),
    .be        (req_be),
    .wdata     (req_wdata),
    .d_req     (d_req),
    .d_kind    (d_kind),
    .d_write   (d_write),
    .d_addr    (d_addr),
    .d_be      (d_be),
    .d_wdata   (d_wdata),
    .d_ack     (d_ack),
    .d_rdata   (d_rdata),
    .done      (seq_done),
    .timed_out (seq_to),
    .rdata     (seq_rdata)
  );

  cpb_lane_unpack u_unpack (
    .size (cap_size),
    .off  (cap_off),
    .raw  (seq_rdata),
    .just (rsp_just)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      busy_q    <= 1'b0;
      cap_size  <= '0;
      cap_off   <= '0;
      cap_write <= 1'b0;
      h_done    <= 1'b0;
      h_rdata   <= '0;
    end else begin
      h_done <= 1'b0;
      if (accept) begin
        if (win_hit) begin
          busy_q    <= 1'b1;
          cap_size  <= h_size;
          cap_off   <= h_addr[1:0];
          cap_write <= h_write;
        end else begin
          h_done  <= 1'b1;
          h_rdata <= (hit_ptr && !h_write) ? ptr_q : '0;
          if (hit_ptr && h_write) ptr_q <= h_wdata;
        end
      end
      if (seq_done) begin
        busy_q  <= 1'b0;
        h_done  <= 1'b1;
        h_rdata <= cap_write ? '0 : (seq_to ? '1 : rsp_just);
      end
    end
  end

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    $rose(d_req) |-> !h_ready);

  a_r10_local_fast: assert property (@(posedge clk) disable iff (rst)
    (h_req && h_ready && !win_hit) |=> (h_done && h_ready && !d_req));

  a_r3_be_legal: assert property (@(posedge clk) disable iff (rst)
    d_req |-> (d_be == 4'hF || d_be == 4'h3 || d_be == 4'hC || $onehot(d_be)));
endmodule

// File: tb/cfgport_bridge_tb_top.sv
module cfgport_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] O_PTR = 12'h064;
  localparam logic [11:0] O_CFG = 12'h068;
  localparam logic [11:0] O_IO  = 12'h06C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_req = 1'b0, h_write = 1'b0;
  logic [11:0] h_addr = '0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_done;
  logic [31:0] h_rdata;
  logic        d_req, d_kind, d_write;
  logic [31:0] d_addr, d_wdata;
  logic [3:0]  d_be;
  logic        d_ack = 1'b0;
  logic [31:0] d_rdata = '0;

  int n_chk = 0, n_fail = 0, cyc_total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgport_bridge dut_i (
    .clk(clk), .rst(rst), .h_req(h_req), .h_write(h_write), .h_addr(h_addr),
    .h_size(h_size), .h_wdata(h_wdata), .h_ready(h_ready), .h_done(h_done),
    .h_rdata(h_rdata), .d_req(d_req), .d_kind(d_kind), .d_write(d_write),
    .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_ack(d_ack), .d_rdata(d_rdata)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[7:0] ^ 8'h44, a[23:16] ^ 8'h33, a[15:8] ^ 8'h22, a[7:0] ^ 8'h11};
  endfunction

  function automatic int shift_of(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 8 * off;
    if (sz == 2'd1) return 16 * off[1];
    return 0;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] off);
    if (sz == 2'd0) return 4'(1 << off);
    if (sz == 2'd1) return off[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [1:0] off,
                                         input logic [31:0] raw);
    logic [31:0] s;
    s = raw >> shift_of(sz, off);
    if (sz == 2'd0) return s & 32'hFF;
    if (sz == 2'd1) return s & 32'hFFFF;
    return s;
  endfunction

  // completer model and request log
  int          lat = 1;
  bit          absent = 1'b0;
  int          cnt = 0;
  bit          prev_req = 1'b0;
  int          hi_cnt = 0;
  int          lg_n = 0;
  logic [31:0] lg_addr [4];
  logic [31:0] lg_wd   [4];
  logic [3:0]  lg_be   [4];
  logic        lg_wr   [4];
  logic        lg_kind [4];

  always @(negedge clk) begin
    if (d_req && !prev_req) begin
      hi_cnt = 0;
      if (lg_n < 4) begin
        lg_addr[lg_n] = d_addr; lg_wd[lg_n] = d_wdata; lg_be[lg_n] = d_be;
        lg_wr[lg_n] = d_write;  lg_kind[lg_n] = d_kind;
        lg_n++;
      end
    end
    if (d_req) hi_cnt++;
    prev_req = d_req;
    if (d_ack) begin
      d_ack = 1'b0; cnt = 0;
    end else if (d_req && !absent) begin
      cnt++;
      if (cnt >= lat) begin
        d_ack = 1'b1; d_rdata = pat(d_addr);
      end
    end else begin
      cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [11:0] ad, input logic [1:0] sz,
                       input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    lg_n = 0;
    h_req = 1'b1; h_write = wr; h_addr = ad; h_size = sz; h_wdata = wd;
    @(negedge clk);
    h_req = 1'b0;
    cyc = 1;
    while (!h_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    rd = h_rdata;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, ptr, a_exp, wd;
    int cyc, idx;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(h_ready === 1'b1, "R11 h_ready", {31'b0, h_ready}, 1);
    chk(h_done === 1'b0,  "R11 h_done", {31'b0, h_done}, 0);
    chk(d_req === 1'b0,   "R11 d_req", {31'b0, d_req}, 0);
    rst = 1'b0;

    // R1 pointer reset value, write, readback, timing
    do_op(1'b0, O_PTR, 2'd2, 32'h0, rd, cyc);
    chk(rd === 32'h0, "R1 reset value", rd, 0);
    do_op(1'b1, O_PTR, 2'd0, 32'hCAFE_1234, rd, cyc);
    chk(cyc == 1, "R1 write latency", cyc, 1);
    do_op(1'b0, O_PTR, 2'd1, 32'h0, rd, cyc);
    chk(rd === 32'hCAFE_1234, "R1 readback", rd, 32'hCAFE_1234);

    // Sweep: kind x direction x size x offset (R2 R3 R4 R5 R6 R7)
    idx = 0;
    for (int k = 0; k < 2; k++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < 3; s++)
          for (int o = 0; o < 4; o++) begin
            ptr = {8'h00, 8'(idx * 5 + 1), 8'(idx * 3 + 8), 8'(8'h3D + idx)};
            wd  = 32'h1000_0000 + idx * 32'h0101_0097;
            lat = 1 + (idx % 3);
            do_op(1'b1, O_PTR, 2'd2, ptr, rd, cyc);
            do_op(w[0], (k == 0 ? O_CFG : O_IO) + 12'(o), 2'(s), wd, rd, cyc);
            a_exp = (k == 0) ? {ptr[31:2], 2'b00} : {16'h0, ptr[15:0]};
            if (k == 0 && w == 1) begin
              chk(lg_n == 2, "R6 cycle count", lg_n, 2);
              chk(lg_wr[0] === 1'b0 && lg_be[0] === 4'hF && lg_addr[0] === {ptr[31:8], 8'h00},
                  "R6 dummy read", lg_addr[0], {ptr[31:8], 8'h00});
              chk(lg_kind[1] === 1'b0 && lg_wr[1] === 1'b1 && lg_addr[1] === a_exp,
                  "R2 write address", lg_addr[1], a_exp);
              chk(lg_be[1] === exp_be(2'(s), 2'(o)), "R3 write enables",
                  {28'b0, lg_be[1]}, {28'b0, exp_be(2'(s), 2'(o))});
              chk(lg_wd[1] === (wd << shift_of(2'(s), 2'(o))), "R4 write steering",
                  lg_wd[1], wd << shift_of(2'(s), 2'(o)));
              chk(rd === 32'h0, "R5 write result", rd, 0);
            end else begin
              chk(lg_n == 1, "R2 cycle count", lg_n, 1);
              chk(lg_kind[0] === k[0] && lg_wr[0] === w[0] && lg_addr[0] === a_exp,
                  (k == 0) ? "R2 address" : "R7 address", lg_addr[0], a_exp);
              chk(lg_be[0] === exp_be(2'(s), 2'(o)), "R3 enables",
                  {28'b0, lg_be[0]}, {28'b0, exp_be(2'(s), 2'(o))});
              if (w == 1)
                chk(lg_wd[0] === (wd << shift_of(2'(s), 2'(o))), "R4 io steering",
                    lg_wd[0], wd << shift_of(2'(s), 2'(o)));
              else
                chk(rd === exp_rd(2'(s), 2'(o), pat(a_exp)), "R5 read extract",
                    rd, exp_rd(2'(s), 2'(o), pat(a_exp)));
            end
            idx++;
          end

    // R8: request during stall is ignored
    lat = 6;
    do_op(1'b1, O_PTR, 2'd2, 32'h0012_3456, rd, cyc);
    @(negedge clk);
    lg_n = 0;
    h_req = 1'b1; h_write = 1'b0; h_addr = O_CFG; h_size = 2'd2;
    @(negedge clk);
    chk(h_ready === 1'b0, "R8 stall", {31'b0, h_ready}, 0);
    h_write = 1'b1; h_addr = O_PTR; h_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    h_req = 1'b0;
    cyc = 0;
    while (!h_done && cyc < 100) begin @(negedge clk); cyc++; end
    chk(h_done === 1'b1, "R8 completion", {31'b0, h_done}, 1);
    do_op(1'b0, O_PTR, 2'd2, 32'h0, rd, cyc);
    chk(rd === 32'h0012_3456, "R8 ignored request", rd, 32'h0012_3456);

    // R9 timeout
    absent = 1'b1;
    do_op(1'b0, O_CFG + 12'd1, 2'd0, 32'h0, rd, cyc);
    chk(rd === 32'hFFFF_FFFF, "R9 read all ones", rd, 32'hFFFF_FFFF);
    chk(hi_cnt == 16, "R9 wait length", hi_cnt, 16);
    do_op(1'b1, O_CFG, 2'd2, 32'h5555_AAAA, rd, cyc);
    chk(lg_n == 2 && h_ready === 1'b1, "R9 write after dummy timeout", lg_n, 2);
    absent = 1'b0;
    lat = 1;

    // R10 other offsets
    do_op(1'b0, 12'h070, 2'd2, 32'h0, rd, cyc);
    chk(rd === 32'h0 && lg_n == 0, "R10 read other", rd, 0);
    chk(cyc == 1, "R10 latency", cyc, 1);
    do_op(1'b1, 12'h060, 2'd2, 32'h1111_1111, rd, cyc);
    chk(lg_n == 0 && cyc == 1, "R10 write other", lg_n, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule